// File: doc/BRIEF.md
# USB PHY Function Control Register

This block holds the 8-bit function control register of a USB transceiver that sits on a low-pin-count register bus. One storage word is reachable through three adjacent bus addresses. The first address loads the written byte as it is. The second ORs the ones of the written byte into the stored value. The third clears every stored bit that is written as a one. All three addresses read back the same word. The stored fields drive the transceiver directly: the speed select, the termination select, the transmit encoding mode, and an active-low suspend bit that puts the PHY into low power.

Bit 5 requests a transceiver reset and clears itself. Once it is set, the block drives the bus direction output high and holds the core in reset for a fixed number of cycles. It then clears the bit and drops direction for one cycle. After that it raises direction again for one cycle while it issues a receive-command status update. If the same access also clears the suspend bit, suspend wins: the reset bit is dropped and no reset runs. Changing the speed field to high-speed starts a clock-stop pulse, which gives the DLL time to calibrate. Leaving low power sets the suspend bit again.

Top module: `phy_fnctl_reg`

## Requirements
- R1: After reset the register reads 0x41 (speed 01b, termination 0, mode 00b, reset bit 0, suspend bit 1, bit 7 0). After reset, dir, core_rst, rxcmd and clk_stop are all 0.
- R2: A read (acc_valid=1, acc_write=0) at address 4, 5 or 6 sets rd_hit=1 and drives the stored word combinationally on rd_data. Any other access drives rd_hit=0 and rd_data=0.
- R3: A write to address 4 loads all eight bits of acc_wdata, including reserved bit 7.
- R4: A write to address 5 ORs acc_wdata into the stored word.
- R5: A write to address 6 clears each stored bit whose acc_wdata bit is 1.
- R6: A write to any address other than 4, 5 or 6 leaves the stored word unchanged.
- R7: A write is accepted while idle. If the resulting word has bit 5 = 1 and bit 6 = 1, then from the next cycle dir=1 and core_rst=1 for RST_CYC cycles (default 16), and bit 5 reads back 1 during that time.
- R8: After the core-reset cycles, bit 5 reads 0 and dir=0 for exactly one cycle. Then dir=1 and rxcmd=1 for exactly one cycle. Then dir returns to 0.
- R9: If an accepted write gives bit 5 = 1 and bit 6 = 0, no reset sequence starts: dir stays 0 and bit 5 is stored as 0. low_power is then 1.
- R10: Writes are ignored from the first core-reset cycle through the rxcmd cycle inclusive. Reads still return the stored word.
- R11: When lp_exit=1 while bit 6 is 0, bit 6 is 1 from the next cycle. This also happens if a write in the same cycle stores bit 6 as 0.
- R12: When the speed field (bits 1:0) changes from a nonzero value to 00b, clk_stop is 1 from the next cycle for CAL_CYC cycles (default 8). A change back to 00b during the pulse restarts it. Writing 00b while the field already holds 00b starts nothing.
- R13: The outputs show the stored fields: xcvr_sel = bits 1:0, term_sel = bit 2, op_mode = bits 4:3, and low_power = NOT bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | 8 | Write data |
| lp_exit | input | 1 | Low-power exit event |
| rd_hit | output | 1 | Read addresses this register |
| rd_data | output | 8 | Read data |
| xcvr_sel | output | 2 | Transceiver speed select |
| term_sel | output | 1 | Termination select |
| op_mode | output | 2 | Transmit encoding mode |
| low_power | output | 1 | PHY in low-power mode |
| dir | output | 1 | Bus direction (1 = PHY drives) |
| core_rst | output | 1 | Transceiver core reset |
| rxcmd | output | 1 | Status update issue strobe |
| clk_stop | output | 1 | Calibration clock-stop request |

## Verification
The read path is combinational. rd_data and rd_hit are therefore checked a few nanoseconds after the access is driven, in the same cycle. Every registered result appears one cycle after the edge that samples the access: the stored word, the field outputs, the start of dir/core_rst and the start of clk_stop. The sequence timing then counts from that edge: RST_CYC cycles of core reset, one gap cycle, and one rxcmd cycle. The reference model advances on the same edge the design samples. Every output is compared against it at the falling edge, so each result is judged in the cycle it is due. Directed reads at fixed points add literal expected values for the alias, the blocking and the priority cases.

// File: rtl/phy_fnctl_pkg.sv
package phy_fnctl_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned SPD_LSB  = 0;
    localparam int unsigned TERM_BIT = 2;
    localparam int unsigned OPM_LSB  = 3;
    localparam int unsigned RST_BIT  = 5;
    localparam int unsigned SUSP_BIT = 6;
    localparam logic [REG_W-1:0] FNCTL_INIT = 8'h41;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CORE,
        SEQ_GAP,
        SEQ_STAT
    } seq_e;
endpackage

// File: rtl/fnctl_decode.sv
module fnctl_decode #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BASE   = 4
) (
    input  logic                                acc_valid,
    input  logic                                acc_write,
    input  logic [ADDR_W-1:0]                   acc_addr,
    input  logic [phy_fnctl_pkg::REG_W-1:0]     acc_wdata,
    input  logic [phy_fnctl_pkg::REG_W-1:0]     cur,
    output logic                                wr_hit,
    output logic                                rd_hit,
    output logic [phy_fnctl_pkg::REG_W-1:0]     merged
);
    localparam int unsigned N_ALIAS = 3;

    logic [N_ALIAS-1:0] alias_hit;

    for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
        localparam logic [ADDR_W-1:0] ALIAS_ADDR = ADDR_W'(BASE + g);
        assign alias_hit[g] = (acc_addr == ALIAS_ADDR);
    end

    assign wr_hit = acc_valid && acc_write && (alias_hit != '0);
    assign rd_hit = acc_valid && !acc_write && (alias_hit != '0);

    always_comb begin
        merged = cur;
        if (alias_hit[0]) merged = acc_wdata;
        if (alias_hit[1]) merged = cur | acc_wdata;
        if (alias_hit[2]) merged = cur & ~acc_wdata;
    end
endmodule

// File: rtl/fnctl_rstseq.sv
module fnctl_rstseq #(
    parameter int unsigned RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic dir,
    output logic core_rst,
    output logic rxcmd
);
    import phy_fnctl_pkg::*;

    localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: if (start) begin
                seq_d.st  = SEQ_CORE;
                seq_d.cnt = CW'(RST_CYC - 1);
            end
            SEQ_CORE: begin
                if (seq_q.cnt == '0) seq_d.st = SEQ_GAP;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            SEQ_GAP:  seq_d.st = SEQ_STAT;
            SEQ_STAT: seq_d.st = SEQ_IDLE;
            default:  seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st != SEQ_IDLE);
    assign done     = (seq_q.st == SEQ_CORE) && (seq_q.cnt == '0);
    assign core_rst = (seq_q.st == SEQ_CORE);
    assign rxcmd    = (seq_q.st == SEQ_STAT);
    assign dir      = core_rst || rxcmd;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R10
endmodule

// File: rtl/fnctl_calstop.sv
module fnctl_calstop #(
    parameter int unsigned CAL_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic clk_stop
);
    localparam int unsigned CW = $clog2(CAL_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trigger)            cnt_d = CW'(CAL_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign clk_stop = (cnt_q != '0);

    AST_STOP_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop) |-> $past(trigger)); // R12
endmodule

// File: rtl/phy_fnctl_reg.sv
module phy_fnctl_reg #(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned BASE    = 4,
    parameter int unsigned RST_CYC = 16,
    parameter int unsigned CAL_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    input  logic              lp_exit,
    output logic              rd_hit,
    output logic [7:0]        rd_data,
    output logic [1:0]        xcvr_sel,
    output logic              term_sel,
    output logic [1:0]        op_mode,
    output logic              low_power,
    output logic              dir,
    output logic              core_rst,
    output logic              rxcmd,
    output logic              clk_stop
);
    import phy_fnctl_pkg::*;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
    } reg_state_t;

    reg_state_t r_d, r_q;

    logic             wr_hit;
    logic [REG_W-1:0] merged;
    logic             busy;
    logic             seq_done;
    logic             seq_start;
    logic             cal_trig;
    logic             wr_ok;

    fnctl_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) i_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .cur       (r_q.ctrl),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .merged    (merged)
    );

    assign wr_ok = wr_hit && !busy;

    always_comb begin
        r_d       = r_q;
        seq_start = 1'b0;
        if (wr_ok) begin
            r_d.ctrl = merged;
            if (merged[RST_BIT]) begin
                if (!merged[SUSP_BIT]) r_d.ctrl[RST_BIT] = 1'b0;
                else                   seq_start = 1'b1;
            end
        end
        if (seq_done) r_d.ctrl[RST_BIT] = 1'b0;
        if (lp_exit && !r_q.ctrl[SUSP_BIT]) r_d.ctrl[SUSP_BIT] = 1'b1;
        cal_trig = (r_d.ctrl[SPD_LSB+:2] == 2'b00) && (r_q.ctrl[SPD_LSB+:2] != 2'b00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: FNCTL_INIT};
        else        r_q <= r_d;
    end

    fnctl_rstseq #(.RST_CYC(RST_CYC)) i_rstseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .busy     (busy),
        .done     (seq_done),
        .dir      (dir),
        .core_rst (core_rst),
        .rxcmd    (rxcmd)
    );

    fnctl_calstop #(.CAL_CYC(CAL_CYC)) i_calstop (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (cal_trig),
        .clk_stop (clk_stop)
    );

    assign rd_data   = rd_hit ? r_q.ctrl : '0;
    assign xcvr_sel  = r_q.ctrl[SPD_LSB+:2];
    assign term_sel  = r_q.ctrl[TERM_BIT];
    assign op_mode   = r_q.ctrl[OPM_LSB+:2];
    assign low_power = !r_q.ctrl[SUSP_BIT];

    AST_SUSPEND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && merged[RST_BIT] && !merged[SUSP_BIT]) |=> (!dir && !r_q.ctrl[RST_BIT])); // R9
    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> $stable(r_q.ctrl)); // R10
    AST_GAP_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (!dir && !r_q.ctrl[RST_BIT])); // R8
    AST_STATUS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |=> (dir && rxcmd)); // R8
    AST_LP_EXIT_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_exit && !r_q.ctrl[SUSP_BIT]) |=> r_q.ctrl[SUSP_BIT]); // R11
    AST_HS_CALIBRATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_d.ctrl[SPD_LSB+:2] == 2'b00) && (r_q.ctrl[SPD_LSB+:2] != 2'b00)) |=> clk_stop); // R12
endmodule

// File: tb/test_phy_fnctl_reg.sv
`timescale 1ns/1ps
module test_phy_fnctl_reg;
    localparam int RST_CYC = 16;
    localparam int CAL_CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [5:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       lp_exit = 1'b0;
    logic       rd_hit;
    logic [7:0] rd_data;
    logic [1:0] xcvr_sel;
    logic       term_sel;
    logic [1:0] op_mode;
    logic       low_power, dir, core_rst, rxcmd, clk_stop;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    phy_fnctl_reg i_phy_fnctl_reg (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .lp_exit(lp_exit),
        .rd_hit(rd_hit), .rd_data(rd_data), .xcvr_sel(xcvr_sel), .term_sel(term_sel),
        .op_mode(op_mode), .low_power(low_power), .dir(dir), .core_rst(core_rst),
        .rxcmd(rxcmd), .clk_stop(clk_stop)
    );

    // behavioural reference: phase 0 idle, 1 core reset, 2 gap, 3 status
    int   m_reg;
    int   m_phase;
    int   m_cnt;
    int   m_cal;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 'h41; m_phase = 0; m_cnt = 0; m_cal = 0;
        end else begin
            int nv;
            bit go;
            nv = m_reg; go = 0;
            if (acc_valid && acc_write && m_phase == 0) begin
                if (acc_addr == 4) nv = acc_wdata;
                else if (acc_addr == 5) nv = m_reg | acc_wdata;
                else if (acc_addr == 6) nv = m_reg & ~acc_wdata & 'hFF;
                if (acc_addr >= 4 && acc_addr <= 6 && nv[5]) begin
                    if (!nv[6]) nv[5] = 0; else go = 1;
                end
            end
            if (m_phase == 1) begin
                if (m_cnt == 0) begin m_phase = 2; nv[5] = 0; end
                else m_cnt--;
            end else if (m_phase == 2) m_phase = 3;
            else if (m_phase == 3) m_phase = 0;
            if (go) begin m_phase = 1; m_cnt = RST_CYC - 1; end
            if (lp_exit && !m_reg[6]) nv[6] = 1;
            if ((nv & 3) == 0 && (m_reg & 3) != 0) m_cal = CAL_CYC;
            else if (m_cal > 0) m_cal--;
            m_reg = nv;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit hit;
        hit = acc_valid && !acc_write && acc_addr >= 4 && acc_addr <= 6;
        chk("R2 rd_hit", rd_hit, hit);
        chk("R2 rd_data", rd_data, hit ? m_reg : 0);
        chk("R7 dir", dir, (m_phase == 1 || m_phase == 3));
        chk("R7 core_rst", core_rst, m_phase == 1);
        chk("R8 rxcmd", rxcmd, m_phase == 3);
        chk("R12 clk_stop", clk_stop, m_cal > 0);
        chk("R13 xcvr_sel", xcvr_sel, m_reg & 3);
        chk("R13 term_sel", term_sel, (m_reg >> 2) & 1);
        chk("R13 op_mode", op_mode, (m_reg >> 3) & 3);
        chk("R9 low_power", low_power, !m_reg[6]);
    end

    task automatic step(input bit v, input bit w, input int a, input int d, input bit lp);
        @(posedge clk); #1;
        acc_valid = v; acc_write = w; acc_addr = 6'(a); acc_wdata = 8'(d); lp_exit = lp;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        step(1, 1, a, d, 0);
        idle(1);
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        step(1, 0, a, 0, 0);
        #3 chk(tag, rd_data, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R1 dir in reset", dir, 0);
        chk("R1 clk_stop in reset", clk_stop, 0);
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rd(4, 'h41, "R1 reset value");
        rd(5, 'h41, "R2 alias 5");
        rd(6, 'h41, "R2 alias 6");
        step(1, 0, 3, 0, 0);
        #3 chk("R2 other address rd_hit", rd_hit, 0);
        wr(4, 'h9A);
        rd(4, 'h9A, "R3 load incl bit7");
        wr(5, 'h44);
        rd(5, 'hDE, "R4 set alias");
        wr(6, 'h82);
        rd(6, 'h5C, "R5 clear alias");
        #5 chk("R12 clk_stop after change to 00", clk_stop, 1);
        wr(7, 'hFF);
        rd(4, 'h5C, "R6 foreign address");
        idle(CAL_CYC + 2);
        wr(4, 'h00);
        #5 chk("R12 no retrigger at 00", clk_stop, 0);
        rd(4, 'h00, "R3 load zero");
        step(0, 0, 0, 0, 1);
        idle(1);
        rd(4, 'h40, "R11 lp exit sets suspend");
        step(1, 1, 5, 'h20, 0);
        step(1, 1, 4, 'h03, 0);
        rd(4, 'h60, "R10 write ignored while busy");
        #5 chk("R7 dir during reset", dir, 1);
        idle(RST_CYC + 3);
        rd(4, 'h40, "R8 reset bit cleared");
        wr(4, 'h21);
        rd(4, 'h01, "R9 suspend wins");
        #5 chk("R9 no dir", dir, 0);
        step(1, 1, 4, 'h05, 1);
        idle(1);
        rd(4, 'h45, "R11 lp exit beats write");
        wr(4, 'h44);
        step(1, 1, 4, 'h45, 0);
        step(1, 1, 4, 'h44, 0);
        idle(CAL_CYC + 3);
        wr(4, 'h61);
        idle(RST_CYC + 4);
        rd(6, 'h41, "R8 second sequence done");
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule